// File: doc/BRIEF.md
# Configuration Capability List Walker

This block finds a capability of a requested type in a device's 256-byte configuration space. A one-cycle start pulse carries an 8-bit target ID. The block first reads the status byte to see whether a capability list exists. If a list exists, it reads the head pointer and then follows the chain of capability blocks one link at a time. Each block begins with an ID byte, and the byte after it holds the link to the next block.

All accesses are single-byte reads made through a request/valid port. Only one read may be outstanding at a time, and a response may take any number of cycles. When the search ends, the block raises a one-cycle done pulse together with the result: found, error, and the byte offset of the matching block. The result stays on the outputs until the next search ends.

The walk is bounded so that a corrupt list cannot hang the block. A pointer that lands inside the standard header region is reported as an error rather than followed.

Top module: `cap_chain_seeker`

## Requirements
- R1: While reset is held and after it is released, rd_req_o, done_o, found_o and err_o are 0 and match_ofs_o is 0x00.
- R2: A start_i pulse seen while the block is idle makes rd_req_o go high in the next cycle, with rd_addr_o = 0x06. A start_i seen while a search is running, including the cycle in which done_o is high, is ignored, and target_id_i is sampled only when a start is accepted.
- R3: rd_req_o is high for exactly one cycle per read. After a request, no further request is made until rd_valid_i has returned the data. The next request, or done_o, follows in the cycle after rd_valid_i. An rd_valid_i that arrives while no read is outstanding has no effect.
- R4: If bit 4 of the byte at offset 0x06 is 0, the search ends after that single read with found_o = 0 and err_o = 0.
- R5: If bit 4 of the byte at 0x06 is 1, the next read is the head pointer at offset 0x34.
- R6: Bits 1:0 of every pointer byte are forced to 0 before use. For a block at offset P, the ID is read at P and the next pointer at P+1, in that order.
- R7: A pointer that is 0x00 after masking ends the search with found_o = 0 and err_o = 0.
- R8: A pointer that is nonzero after masking but below 0x40 ends the search with err_o = 1 and found_o = 0.
- R9: When the ID byte of a block equals the target, the search ends with found_o = 1, err_o = 0 and match_ofs_o = that block's offset. The first match in list order wins, and no further reads are made.
- R10: At most 48 blocks are visited. A nonzero valid pointer met after the 48th block ends the search with err_o = 1 and found_o = 0, so a search makes at most 98 reads.
- R11: done_o is high for exactly one cycle per search. found_o, err_o and match_ofs_o change only in a cycle in which done_o is high, and they hold their value until the next search ends. When the search ends without a match, match_ofs_o is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| target_id_i | input | 8 | Capability ID to look for, sampled with an accepted start |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | 8 | Byte offset of the requested read |
| rd_valid_i | input | 1 | Read data is valid this cycle |
| rd_data_i | input | 8 | Read data byte |
| done_o | output | 1 | One-cycle end-of-search pulse |
| found_o | output | 1 | Last search found the target |
| err_o | output | 1 | Last search hit a malformed pointer or the hop limit |
| match_ofs_o | output | 8 | Offset of the matching block, or 0x00 |

## Verification
The assertions check the following on every cycle:
- done and request pulses last a single cycle;
- no request is made while one is outstanding;
- an accepted start is followed by the status read, and a start during a search is refused;
- found and error never appear together;
- a reported offset is aligned and lies at or above 0x40;
- the result outputs change only with done;
- the hop and read counts stay within their limits.

Only the bench scenarios can show the rest, because each depends on memory contents:
- which addresses are read, and in what order;
- that masking turns a pointer into a terminator;
- that the first of two equal IDs wins;
- that a list of exactly 48 blocks completes cleanly while a circular list ends in an error.

// File: rtl/cap_seek_pkg.sv
package cap_seek_pkg;

  localparam int CFG_AW = 8;
  localparam int CFG_DW = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } seek_state_e;

  typedef enum logic [1:0] {
    PH_STATUS,
    PH_LINK,
    PH_ID
  } seek_phase_e;

  typedef enum logic [1:0] {
    LINK_END,
    LINK_BAD,
    LINK_GO
  } link_kind_e;

  // Sort a masked pointer into terminator, malformed, or followable.
  function automatic link_kind_e classify_link(input logic [CFG_AW-1:0] ptr,
                                               input logic [CFG_AW-1:0] floor_ptr);
    if (ptr == '0)
      return LINK_END;
    else if (ptr < floor_ptr)
      return LINK_BAD;
    else
      return LINK_GO;
  endfunction

  // Offset of the link byte inside the block that starts at blk.
  function automatic logic [CFG_AW-1:0] link_field_addr(input logic [CFG_AW-1:0] blk);
    return blk + CFG_AW'(1);
  endfunction

  // True when the block's ID byte is the one being searched for.
  function automatic logic id_hit(input logic [CFG_DW-1:0] id_byte,
                                  input logic [CFG_DW-1:0] want);
    return id_byte == want;
  endfunction

endpackage

// File: rtl/cap_seek_link_dec.sv
module cap_seek_link_dec
  import cap_seek_pkg::*;
#(
  parameter int                RSVD_BITS = 2,
  parameter logic [CFG_AW-1:0] MIN_LINK  = 8'h40
) (
  input  logic [CFG_DW-1:0] raw_i,
  output logic [CFG_AW-1:0] ptr_o,
  output link_kind_e        kind_o
);

  logic [CFG_AW-1:0] keep;

  // Reserved low bits are dropped; the rest pass through.
  for (genvar gi = 0; gi < CFG_AW; gi++) begin : g_keep
    if (gi < RSVD_BITS) begin : g_rsvd
      assign keep[gi] = 1'b0;
    end else begin : g_pass
      assign keep[gi] = 1'b1;
    end
  end

  assign ptr_o  = raw_i & keep;
  assign kind_o = classify_link(ptr_o, MIN_LINK);

endmodule

// File: rtl/cap_seek_hop_ctr.sv
module cap_seek_hop_ctr #(
  parameter int MAX_HOPS = 48,
  localparam int HOP_W = $clog2(MAX_HOPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic             at_limit_o,
  output logic [HOP_W-1:0] count_o
);

  localparam logic [HOP_W-1:0] LIMIT = HOP_W'(MAX_HOPS);

  logic [HOP_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (clr_i)
      cnt_q <= '0;
    else if (inc_i && (cnt_q != LIMIT))
      cnt_q <= cnt_q + HOP_W'(1);
  end

  assign at_limit_o = (cnt_q == LIMIT);
  assign count_o    = cnt_q;

endmodule

// File: rtl/cap_seek_ctrl.sv
module cap_seek_ctrl
  import cap_seek_pkg::*;
#(
  parameter logic [CFG_AW-1:0] STAT_ADDR = 8'h06,
  parameter logic [CFG_AW-1:0] HEAD_ADDR = 8'h34,
  parameter int                LIST_BIT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CFG_DW-1:0] target_i,
  input  logic              rd_valid_i,
  input  logic [CFG_DW-1:0] rd_data_i,
  input  logic [CFG_AW-1:0] link_ptr_i,
  input  link_kind_e        link_kind_i,
  input  logic              hop_limit_i,
  output logic              rd_req_o,
  output logic [CFG_AW-1:0] rd_addr_o,
  output logic              done_o,
  output logic              found_o,
  output logic              err_o,
  output logic [CFG_AW-1:0] ofs_o,
  output logic              hop_clr_o,
  output logic              hop_inc_o,
  output logic              start_take_o
);

  seek_state_e       st_q, st_d;
  seek_phase_e       ph_q, ph_d;
  logic [CFG_AW-1:0] addr_q, addr_d;
  logic [CFG_AW-1:0] blk_q, blk_d;
  logic [CFG_DW-1:0] tgt_q, tgt_d;
  logic              found_q, err_q;
  logic [CFG_AW-1:0] ofs_q;

  logic fin, fin_found, fin_err;

  always_comb begin
    st_d      = st_q;
    ph_d      = ph_q;
    addr_d    = addr_q;
    blk_d     = blk_q;
    tgt_d     = tgt_q;
    fin       = 1'b0;
    fin_found = 1'b0;
    fin_err   = 1'b0;
    hop_clr_o = 1'b0;
    hop_inc_o = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d      = ST_REQ;
          ph_d      = PH_STATUS;
          addr_d    = STAT_ADDR;
          tgt_d     = target_i;
          hop_clr_o = 1'b1;
        end
      end
      ST_REQ: st_d = ST_WAIT;
      ST_WAIT: begin
        if (rd_valid_i) begin
          st_d = ST_REQ;
          case (ph_q)
            PH_STATUS: begin
              if (rd_data_i[LIST_BIT]) begin
                ph_d   = PH_LINK;
                addr_d = HEAD_ADDR;
              end else begin
                fin = 1'b1;
              end
            end
            PH_LINK: begin
              case (link_kind_i)
                LINK_END: fin = 1'b1;
                LINK_BAD: begin
                  fin     = 1'b1;
                  fin_err = 1'b1;
                end
                default: begin
                  if (hop_limit_i) begin
                    fin     = 1'b1;
                    fin_err = 1'b1;
                  end else begin
                    hop_inc_o = 1'b1;
                    blk_d     = link_ptr_i;
                    addr_d    = link_ptr_i;
                    ph_d      = PH_ID;
                  end
                end
              endcase
            end
            default: begin
              if (id_hit(rd_data_i, tgt_q)) begin
                fin       = 1'b1;
                fin_found = 1'b1;
              end else begin
                addr_d = link_field_addr(blk_q);
                ph_d   = PH_LINK;
              end
            end
          endcase
          if (fin) st_d = ST_DONE;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ph_q    <= PH_STATUS;
      addr_q  <= '0;
      blk_q   <= '0;
      tgt_q   <= '0;
      found_q <= 1'b0;
      err_q   <= 1'b0;
      ofs_q   <= '0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      addr_q <= addr_d;
      blk_q  <= blk_d;
      tgt_q  <= tgt_d;
      if (fin) begin
        found_q <= fin_found;
        err_q   <= fin_err;
        ofs_q   <= fin_found ? blk_q : '0;
      end
    end
  end

  assign start_take_o = (st_q == ST_IDLE) && start_i;
  assign rd_req_o     = (st_q == ST_REQ);
  assign rd_addr_o    = addr_q;
  assign done_o       = (st_q == ST_DONE);
  assign found_o      = found_q;
  assign err_o        = err_q;
  assign ofs_o        = ofs_q;

endmodule

// File: rtl/cap_chain_seeker.sv
module cap_chain_seeker
  import cap_seek_pkg::*;
#(
  parameter int                MAX_HOPS  = 48,
  parameter int                RSVD_BITS = 2,
  parameter logic [CFG_AW-1:0] MIN_LINK  = 8'h40,
  parameter logic [CFG_AW-1:0] STAT_ADDR = 8'h06,
  parameter logic [CFG_AW-1:0] HEAD_ADDR = 8'h34,
  parameter int                LIST_BIT  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] target_id_i,
  output logic       rd_req_o,
  output logic [7:0] rd_addr_o,
  input  logic       rd_valid_i,
  input  logic [7:0] rd_data_i,
  output logic       done_o,
  output logic       found_o,
  output logic       err_o,
  output logic [7:0] match_ofs_o
);

  localparam int HOP_W = $clog2(MAX_HOPS + 1);

  // Internal events, brought out as named wires for the checker.
  logic [CFG_AW-1:0] link_ptr;
  link_kind_e        link_kind;
  logic              hop_clr, hop_inc, hop_limit;
  logic [HOP_W-1:0]  hop_cnt;
  logic              start_take;

  cap_seek_link_dec #(
    .RSVD_BITS (RSVD_BITS),
    .MIN_LINK  (MIN_LINK)
  ) u_dec (
    .raw_i  (rd_data_i),
    .ptr_o  (link_ptr),
    .kind_o (link_kind)
  );

  cap_seek_hop_ctr #(
    .MAX_HOPS (MAX_HOPS)
  ) u_hops (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (hop_clr),
    .inc_i      (hop_inc),
    .at_limit_o (hop_limit),
    .count_o    (hop_cnt)
  );

  cap_seek_ctrl #(
    .STAT_ADDR (STAT_ADDR),
    .HEAD_ADDR (HEAD_ADDR),
    .LIST_BIT  (LIST_BIT)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .target_i     (target_id_i),
    .rd_valid_i   (rd_valid_i),
    .rd_data_i    (rd_data_i),
    .link_ptr_i   (link_ptr),
    .link_kind_i  (link_kind),
    .hop_limit_i  (hop_limit),
    .rd_req_o     (rd_req_o),
    .rd_addr_o    (rd_addr_o),
    .done_o       (done_o),
    .found_o      (found_o),
    .err_o        (err_o),
    .ofs_o        (match_ofs_o),
    .hop_clr_o    (hop_clr),
    .hop_inc_o    (hop_inc),
    .start_take_o (start_take)
  );

endmodule

// File: rtl/cap_chain_seeker_chk.sv
module cap_chain_seeker_chk #(
  parameter int         MAX_HOPS  = 48,
  parameter logic [7:0] MIN_LINK  = 8'h40,
  parameter logic [7:0] STAT_ADDR = 8'h06,
  parameter logic [7:0] HEAD_ADDR = 8'h34,
  localparam int HOP_W = $clog2(MAX_HOPS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             rd_req_o,
  input logic [7:0]       rd_addr_o,
  input logic             rd_valid_i,
  input logic             done_o,
  input logic             found_o,
  input logic             err_o,
  input logic [7:0]       match_ofs_o,
  input logic             start_take,
  input logic [HOP_W-1:0] hop_cnt
);

  localparam int MAX_READS = 2 * MAX_HOPS + 2;
  localparam int RQ_W      = $clog2(MAX_READS + 2) + 1;

  logic            pend_q;
  logic [RQ_W-1:0] reads_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          pend_q <= 1'b0;
    else if (rd_req_o)   pend_q <= 1'b1;
    else if (rd_valid_i) pend_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          reads_q <= '0;
    else if (start_take) reads_q <= '0;
    else if (rd_req_o)   reads_q <= reads_q + RQ_W'(1);
  end

  p_start_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_take |=> (rd_req_o && rd_addr_o == STAT_ADDR));

  p_busy_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (pend_q || rd_req_o || done_o)) |-> !start_take);

  p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> !rd_req_o);

  p_one_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> !pend_q);

  p_link_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && rd_addr_o != STAT_ADDR && rd_addr_o != HEAD_ADDR) |-> (rd_addr_o >= MIN_LINK));

  p_no_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !(found_o && err_o));

  p_found_ofs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && found_o) |-> (match_ofs_o >= MIN_LINK && match_ofs_o[1:0] == 2'b00));

  p_hop_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hop_cnt <= HOP_W'(MAX_HOPS));

  p_read_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reads_q <= RQ_W'(MAX_READS));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({found_o, err_o, match_ofs_o}) |-> done_o);

endmodule

bind cap_chain_seeker cap_chain_seeker_chk #(
  .MAX_HOPS  (MAX_HOPS),
  .MIN_LINK  (MIN_LINK),
  .STAT_ADDR (STAT_ADDR),
  .HEAD_ADDR (HEAD_ADDR)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .rd_req_o    (rd_req_o),
  .rd_addr_o   (rd_addr_o),
  .rd_valid_i  (rd_valid_i),
  .done_o      (done_o),
  .found_o     (found_o),
  .err_o       (err_o),
  .match_ofs_o (match_ofs_o),
  .start_take  (start_take),
  .hop_cnt     (hop_cnt)
);

// File: tb/cap_chain_seeker_test.sv
`timescale 1ns/1ps
module cap_chain_seeker_test;

  localparam int HOPS = 48;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [7:0] target_id_i;
  logic       rd_req_o;
  logic [7:0] rd_addr_o;
  logic       rd_valid_i;
  logic [7:0] rd_data_i;
  logic       done_o;
  logic       found_o;
  logic       err_o;
  logic [7:0] match_ofs_o;

  always #2 clk = ~clk;

  cap_chain_seeker uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .target_id_i (target_id_i),
    .rd_req_o    (rd_req_o),
    .rd_addr_o   (rd_addr_o),
    .rd_valid_i  (rd_valid_i),
    .rd_data_i   (rd_data_i),
    .done_o      (done_o),
    .found_o     (found_o),
    .err_o       (err_o),
    .match_ofs_o (match_ofs_o)
  );

  logic [7:0] cfg [256];
  logic [7:0] exp_q [$];
  bit         e_found, e_err;
  logic [7:0] e_ofs;
  int         n_run = 0;
  int         n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  task automatic clear_cfg();
    for (int i = 0; i < 256; i++) cfg[i] = 8'h00;
  endtask

  task automatic put_blk(input int p, input logic [7:0] id, input logic [7:0] nxt);
    cfg[p]     = id;
    cfg[p + 1] = nxt;
  endtask

  // Behavioural restatement of the walk: expected read list and result.
  function automatic void plan_walk(input logic [7:0] tgt);
    int p;
    int hops;
    exp_q.delete();
    e_found = 0;
    e_err   = 0;
    e_ofs   = 8'h00;
    exp_q.push_back(8'h06);
    if (cfg[6][4] == 1'b0) return;
    exp_q.push_back(8'h34);
    p    = int'(cfg[8'h34]) & 'hFC;
    hops = 0;
    forever begin
      if (p == 0) return;
      if (p < 'h40) begin e_err = 1; return; end
      if (hops == HOPS) begin e_err = 1; return; end
      hops++;
      exp_q.push_back(8'(p));
      if (cfg[p] == tgt) begin e_found = 1; e_ofs = 8'(p); return; end
      exp_q.push_back(8'(p + 1));
      p = int'(cfg[p + 1]) & 'hFC;
    end
  endfunction

  // Runs one search; acts as memory, compares the outputs every clock.
  task automatic run(input logic [7:0] tgt, input int lat_base, input int poke_cyc,
                     input logic [7:0] poke_tgt, input bit poke_done, input string tag);
    int         cyc;
    int         lat_left;
    int         nreads;
    bit         pend, exp_req, exp_done, nreq, ndone, fin;
    logic [7:0] a_l;
    plan_walk(tgt);
    @(negedge clk);
    start_i     = 1'b1;
    target_id_i = tgt;
    exp_req  = 1; exp_done = 0; pend = 0; cyc = 0; nreads = 0; fin = 0;
    lat_left = 0; a_l = 8'h00;
    while (!fin) begin
      @(negedge clk);
      cyc++;
      start_i    = 1'b0;
      rd_valid_i = 1'b0;
      nreq = 0; ndone = 0;
      chk(rd_req_o == exp_req, "R3", {tag, " request timing"}, int'(rd_req_o), int'(exp_req));
      chk(done_o == exp_done, "R11", {tag, " done timing"}, int'(done_o), int'(exp_done));
      if (pend) begin
        if (lat_left == 0) begin
          rd_valid_i = 1'b1;
          rd_data_i  = cfg[a_l];
          pend       = 0;
          if (exp_q.size() == 0) ndone = 1;
          else nreq = 1;
        end else begin
          lat_left--;
        end
      end
      if (rd_req_o) begin
        if (exp_q.size() == 0) begin
          chk(0, "R10", {tag, " read beyond the expected walk"}, int'(rd_addr_o), 0);
        end else begin
          a_l = exp_q.pop_front();
          chk(rd_addr_o == a_l, "R5/R6", {tag, " read address"}, int'(rd_addr_o), int'(a_l));
        end
        a_l      = rd_addr_o;
        pend     = 1;
        nreads++;
        lat_left = (lat_base + nreads * 3) % 4;
      end
      if (done_o) begin
        chk(found_o == e_found, "R9", {tag, " found flag"}, int'(found_o), int'(e_found));
        chk(err_o == e_err, "R8", {tag, " error flag"}, int'(err_o), int'(e_err));
        chk(match_ofs_o == e_ofs, "R9", {tag, " match offset"}, int'(match_ofs_o), int'(e_ofs));
        chk(exp_q.size() == 0, "R6", {tag, " reads left unissued"}, exp_q.size(), 0);
        if (poke_done) start_i = 1'b1;
        fin = 1;
      end
      if (cyc == poke_cyc && !fin) begin
        start_i     = 1'b1;
        target_id_i = poke_tgt;
      end
      exp_req  = nreq;
      exp_done = ndone;
      if (cyc > 4000) begin
        chk(0, "R11", {tag, " search never ended"}, cyc, 0);
        fin = 1;
      end
    end
    @(negedge clk);
    start_i = 1'b0;
    chk(rd_req_o == 1'b0 && done_o == 1'b0, "R2", {tag, " idle after done"}, int'(rd_req_o), 0);
  endtask

  task automatic result_is(input bit f, input bit e, input logic [7:0] o, input string req, input string tag);
    chk(found_o == f, req, {tag, " held found"}, int'(found_o), int'(f));
    chk(err_o == e, req, {tag, " held error"}, int'(err_o), int'(e));
    chk(match_ofs_o == o, req, {tag, " held offset"}, int'(match_ofs_o), int'(o));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R11 watchdog expired: actual 0x0 expected 0x1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; target_id_i = 8'h00;
    rd_valid_i = 1'b0; rd_data_i = 8'h00;
    clear_cfg();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rd_req_o == 0 && done_o == 0, "R1", "outputs in reset", int'(rd_req_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_req_o == 0 && done_o == 0, "R1", "request/done after reset", int'(done_o), 0);
    result_is(0, 0, 8'h00, "R1", "reset");

    // R4: no list
    cfg[6] = 8'hEF; cfg[7] = 8'hFF; cfg[8'h34] = 8'h40; put_blk('h40, 8'h01, 8'h00);
    run(8'h01, 1, 0, 8'h00, 0, "no-list");
    result_is(0, 0, 8'h00, "R4", "no-list");

    // Three-block list, head pointer with reserved bits set
    cfg[6] = 8'h10; cfg[8'h34] = 8'h43;
    put_blk('h40, 8'h01, 8'h52);
    put_blk('h50, 8'h05, 8'h61);
    put_blk('h60, 8'h07, 8'h00);
    run(8'h07, 0, 3, 8'h01, 0, "third");
    result_is(1, 0, 8'h60, "R9", "third");
    run(8'h10, 2, 0, 8'h00, 1, "absent");
    result_is(0, 0, 8'h00, "R7", "absent");
    run(8'h01, 3, 2, 8'h07, 0, "first");
    result_is(1, 0, 8'h40, "R9", "first");

    // R3: stray valid while idle
    @(negedge clk); rd_valid_i = 1'b1; rd_data_i = 8'h10;
    @(negedge clk); rd_valid_i = 1'b0;
    chk(rd_req_o == 0 && done_o == 0, "R3", "stray valid while idle", int'(rd_req_o), 0);
    result_is(1, 0, 8'h40, "R11", "after stray valid");

    // Duplicate IDs: first in list order wins
    cfg[8'h60] = 8'h05;
    run(8'h05, 1, 0, 8'h00, 0, "dup");
    result_is(1, 0, 8'h50, "R9", "dup");

    // Malformed link below the floor
    cfg[8'h61] = 8'h3C;
    run(8'hAA, 0, 0, 8'h00, 0, "low-link");
    result_is(0, 1, 8'h00, "R8", "low-link");

    // Head pointer masks to zero; head below floor
    cfg[8'h34] = 8'h03;
    run(8'h05, 2, 0, 8'h00, 0, "head-zero");
    result_is(0, 0, 8'h00, "R7", "head-zero");
    cfg[8'h34] = 8'h20;
    run(8'h05, 1, 0, 8'h00, 0, "head-low");
    result_is(0, 1, 8'h00, "R8", "head-low");

    // Exactly 48 blocks, then a circular list
    clear_cfg();
    cfg[6] = 8'h10; cfg[8'h34] = 8'h40;
    for (int i = 0; i < HOPS; i++)
      put_blk('h40 + 4 * i, 8'h20, (i < HOPS - 1) ? 8'('h44 + 4 * i) : 8'h00);
    run(8'h99, 0, 0, 8'h00, 0, "full48");
    result_is(0, 0, 8'h00, "R10", "full48");
    cfg[8'hFC] = 8'h77;
    run(8'h77, 1, 0, 8'h00, 0, "last48");
    result_is(1, 0, 8'hFC, "R10", "last48");
    cfg[8'hFC] = 8'h20; cfg[8'hFD] = 8'h41;
    run(8'h99, 2, 5, 8'h20, 1, "loop");
    result_is(0, 1, 8'h00, "R10", "loop");

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

endmodule